// File: doc/BRIEF.md
# Grouped Countdown Timer Unit

This block gathers two or three independent countdown timer channels behind one byte-addressed register window driven by a simple single-cycle read/write strobe. A shared start register holds one run bit per channel, so software can start, stop and restart any mix of channels with a single write. An optional one-bit output-control register sits at the bottom of the window. The third channel, which alone carries a capture register, is a build-time option.

Each channel counts down on a prescaled tick. When it reaches zero it reloads from its reload register and sets an underflow flag. The flag, gated by the channel's interrupt enable, drives that channel's own interrupt pin. Any access that the build does not support raises a one-cycle pulse on a shared error output. Unaligned addresses, holes in the map, missing options and reserved settings all count as such accesses.

Top module: `tmr_group`

## Requirements
- R1: After reset every reload and count register reads 0xFFFFFFFF, every control register, capture register, the start register and the output-control register read 0, and `irq` and `err` are low.
- R2: Byte address 0x00 is the output-control register; it keeps only bit 0, so writing 0xFFFFFFFF reads back 0x1. Byte address 0x04 is the start register and reads back the full value last written.
- R3: Channels are decoded at bases 0x08, 0x14 and 0x20. The highest base not above the address is chosen, and the difference is the local offset: 0x0 reload, 0x4 count, 0x8 control, 0xC capture (channel 2 only).
- R4: Start-register bit i (i = 0, 1, 2) lets channel i count. A channel whose bit is 0 keeps its count unchanged.
- R5: Clearing a start bit holds the count. Setting it again resumes counting from the held value, without reloading.
- R6: A running channel ticks once every 4 << (2*psel) clock cycles, where psel is control bits [2:0] and valid values are 0..4. On a tick the count decrements by one, or, when it is already zero, takes the reload value and sets the underflow flag (control bit 4).
- R7: The `irq` bit of a channel goes high one cycle after its underflow flag and its enable (control bit 3) are both set. Writing control with bit 4 = 0 clears the flag. Writing bit 4 = 1 leaves it unchanged.
- R8: Read data appears on `rdata` on the clock edge that samples `rd_en`, and holds until the next read.
- R9: `err` pulses for one cycle after any of these accesses: an unaligned address; an address outside the map; 0x00 without the output-control option; 0x20 and above without the third channel; a start write with bit 2 set and no third channel; a control write with psel 5..7. In the last case the control register stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 8 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt; bit 2 is 0 without the third channel |
| err | output | 1 | One-cycle pulse after an unsupported access |

## Verification
On every cycle, assertions check four things: a stopped channel's count stays put unless it is written; an underflow tick reloads and raises the flag; the start register changes only on a start write; and every access that decodes to nothing is followed by an error pulse. The bench's scenarios show the exact interrupt latency for a given reload and prescaler, that stopping and restarting resumes from the held count, and how writing the flag bit clears it or leaves it set. They also cover read-back of each register in the irregular map, and the error cases of a build with no third channel and no output-control register.

// File: rtl/tmr_group_pkg.sv
package tmr_group_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LOC_W  = 4;
  localparam logic [ADDR_W-1:0] BASE_CH0 = 8'h08;
  localparam logic [ADDR_W-1:0] BASE_CH1 = 8'h14;
  localparam logic [ADDR_W-1:0] BASE_CH2 = 8'h20;
  localparam logic [ADDR_W-1:0] ADDR_START = 8'h04;
  localparam logic [LOC_W-1:0] LOC_RELOAD = 4'h0;
  localparam logic [LOC_W-1:0] LOC_COUNT  = 4'h4;
  localparam logic [LOC_W-1:0] LOC_CTRL   = 4'h8;
  localparam logic [LOC_W-1:0] LOC_CAP    = 4'hC;
  localparam int PSEL_MAX = 4;
  typedef enum logic [1:0] {SEL_NONE, SEL_OUTCTL, SEL_START, SEL_CHAN} tmr_sel_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_group_pkg::*;
#(
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output tmr_sel_e          sel,
  output logic [1:0]        ch,
  output logic [LOC_W-1:0]  loc
);
  always_comb begin
    sel = SEL_NONE;
    ch  = 2'd0;
    loc = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= BASE_CH2) begin
        if (HAS_CH2 && (addr <= BASE_CH2 + 8'd12)) begin
          sel = SEL_CHAN;
          ch  = 2'd2;
          loc = LOC_W'(addr - BASE_CH2);
        end
      end else if (addr >= BASE_CH1) begin
        sel = SEL_CHAN;
        ch  = 2'd1;
        loc = LOC_W'(addr - BASE_CH1);
      end else if (addr >= BASE_CH0) begin
        sel = SEL_CHAN;
        ch  = 2'd0;
        loc = LOC_W'(addr - BASE_CH0);
      end else if (addr == ADDR_START) begin
        sel = SEL_START;
      end else if (HAS_OUTCTL) begin
        sel = SEL_OUTCTL;
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_group_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr,
  input  logic [LOC_W-1:0]  loc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              cfg_bad,
  output logic              irq
);
  localparam int PRE_W = 2 * PSEL_MAX + 2;

  logic [CNT_W-1:0]  reload_q, cnt_q;
  logic [2:0]        psel_q;
  logic              ie_q, flag_q, irq_q;
  logic [DATA_W-1:0] cap_q;
  logic [PRE_W-1:0]  pcnt_q;
  logic [PRE_W:0]    last;
  logic              tick;

  assign last    = ((PRE_W+1)'(4) << {psel_q, 1'b0}) - 1'b1;
  assign tick    = run && ({1'b0, pcnt_q} >= last);
  assign cfg_bad = wr && (loc == LOC_CTRL) && (wdata[2:0] > 3'(PSEL_MAX));
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
      psel_q   <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      cap_q    <= '0;
      pcnt_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (run) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
      if (tick) begin
        if (cnt_q == '0) begin
          cnt_q  <= reload_q;
          flag_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (wr) begin
        case (loc)
          LOC_RELOAD: reload_q <= wdata[CNT_W-1:0];
          LOC_COUNT:  cnt_q    <= wdata[CNT_W-1:0];
          LOC_CTRL: if (!cfg_bad) begin
            psel_q <= wdata[2:0];
            ie_q   <= wdata[3];
            if (!wdata[4]) flag_q <= 1'b0;
          end
          LOC_CAP: if (HAS_CAP) cap_q <= wdata;
          default: ;
        endcase
      end
      irq_q <= flag_q && ie_q;
    end
  end

  always_comb begin
    case (loc)
      LOC_RELOAD: rd_val = DATA_W'(reload_q);
      LOC_COUNT:  rd_val = DATA_W'(cnt_q);
      LOC_CTRL:   rd_val = DATA_W'({flag_q, ie_q, psel_q});
      LOC_CAP:    rd_val = HAS_CAP ? cap_q : '0;
      default:    rd_val = '0;
    endcase
  end

  // R5: a stopped channel keeps its count unless software writes it
  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr && loc == LOC_COUNT)) |=> $stable(cnt_q));

  // R6: a tick at zero reloads and raises the flag
  a_r6_underflow_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0 && !wr) |=> (flag_q && cnt_q == $past(reload_q)));
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_group_pkg::*;
#(
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        irq,
  output logic              err
);
  localparam int NCH = 3;

  tmr_sel_e          sel;
  logic [1:0]        ch;
  logic [LOC_W-1:0]  loc;
  logic [DATA_W-1:0] start_q, rd_d;
  logic              outctl_q, err_d, bad_start, acc_bad;
  logic [DATA_W-1:0] ch_rd [NCH];
  logic [NCH-1:0]    ch_bad, ch_irq;

  tmr_decode #(.HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr(addr), .sel(sel), .ch(ch), .loc(loc)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i < 2 || HAS_CH2) begin : g_on
      tmr_chan #(.CNT_W(CNT_W), .HAS_CAP(i == 2)) u_chan (
        .clk(clk), .rst(rst), .run(start_q[i]),
        .wr(wr_en && sel == SEL_CHAN && ch == 2'(i)),
        .loc(loc), .wdata(wdata), .rd_val(ch_rd[i]),
        .cfg_bad(ch_bad[i]), .irq(ch_irq[i])
      );
    end else begin : g_off
      assign ch_rd[i]  = '0;
      assign ch_bad[i] = 1'b0;
      assign ch_irq[i] = 1'b0;
    end
  end

  assign bad_start = wr_en && sel == SEL_START && !HAS_CH2 && wdata[2];
  assign acc_bad   = (wr_en || rd_en) && sel == SEL_NONE;
  assign err_d     = acc_bad || bad_start || (|ch_bad);
  assign irq       = ch_irq;

  always_comb begin
    case (sel)
      SEL_OUTCTL: rd_d = DATA_W'(outctl_q);
      SEL_START:  rd_d = start_q;
      SEL_CHAN: begin
        case (ch)
          2'd0:    rd_d = ch_rd[0];
          2'd1:    rd_d = ch_rd[1];
          default: rd_d = ch_rd[2];
        endcase
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      err      <= 1'b0;
      start_q  <= '0;
      outctl_q <= 1'b0;
    end else begin
      err <= err_d;
      if (rd_en) rdata <= rd_d;
      if (wr_en && sel == SEL_START)  start_q  <= wdata;
      if (wr_en && sel == SEL_OUTCTL) outctl_q <= wdata[0];
    end
  end

  // R2: the start register changes only on a start write
  a_r2_start_stable: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_START) |=> $stable(start_q));

  // R9: an access that decodes to nothing is followed by an error pulse
  a_r9_bad_access_err: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && sel == SEL_NONE) |=> err);
endmodule

// File: tb/tmr_group_bench.sv
module tmr_group_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {is_write, addr, wdata, expected rdata, expected err}
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b0},   // R2 outctl write
    {1'b0, 8'h00, 32'h0, 32'h0000_0001, 1'b0},   // R2 only bit 0 kept
    {1'b1, 8'h08, 32'h55, 32'h0, 1'b0},          // R3 ch0 reload
    {1'b0, 8'h08, 32'h0, 32'h55, 1'b0},
    {1'b1, 8'h18, 32'h66, 32'h0, 1'b0},          // R3 ch1 count
    {1'b0, 8'h18, 32'h0, 32'h66, 1'b0},
    {1'b1, 8'h2C, 32'hABCD, 32'h0, 1'b0},        // R3 ch2 capture
    {1'b0, 8'h2C, 32'h0, 32'hABCD, 1'b0},
    {1'b0, 8'h14, 32'h0, 32'hFFFF_FFFF, 1'b0},   // R3 ch1 reload untouched
    {1'b1, 8'h01, 32'h1, 32'h0, 1'b1},           // R9 unaligned
    {1'b0, 8'h30, 32'h0, 32'h0, 1'b1},           // R9 beyond map
    {1'b1, 8'h1C, 32'h5, 32'h0, 1'b1},           // R9 reserved psel
    {1'b0, 8'h1C, 32'h0, 32'h0, 1'b0}            // R9 control unchanged
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic [2:0]  irq, irq_s;
  logic        err, err_s;
  int checks = 0, fails = 0;
  logic [31:0] v0, v1, v2;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_group u_tmr_group (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .err(err));
  tmr_group #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) u_small (.clk(clk), .rst(rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_s), .irq(irq_s), .err(err_s));

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    wr_en = w; rd_en = !w; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk(irq == 3'b0 && err == 1'b0, "R1 irq/err", {28'h0, irq, err}, 32'h0);
    acc(1'b0, 8'h0C, '0); chk(rdata == 32'hFFFF_FFFF, "R1 ch0 count", rdata, 32'hFFFF_FFFF);
    acc(1'b0, 8'h10, '0); chk(rdata == 32'h0, "R1 ch0 control", rdata, 32'h0);
    acc(1'b0, 8'h04, '0); chk(rdata == 32'h0, "R1 start", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][73], VEC[i][72:65], VEC[i][64:33]);
      chk(err == VEC[i][0], "R9 err per vector", {31'h0, err}, {31'h0, VEC[i][0]});
      if (!VEC[i][73])
        chk(rdata == VEC[i][32:1], "R3/R8 read vector", rdata, VEC[i][32:1]);
    end

    // R6: reload 2, count 2, psel 0, enable: irq after (2+1)*4+1 cycles
    acc(1'b1, 8'h08, 32'd2);
    acc(1'b1, 8'h0C, 32'd2);
    acc(1'b1, 8'h10, 32'h8);
    acc(1'b1, 8'h04, 32'h1);
    begin
      int cyc = 0;
      while (!irq[0] && cyc < 100) begin @(posedge clk); #1; cyc++; end
      chk(cyc == 13, "R6 irq latency", cyc, 32'd13);
    end
    // R7 flag behaviour
    acc(1'b1, 8'h04, 32'h0);
    acc(1'b0, 8'h10, '0); chk(rdata == 32'h18, "R7 flag read", rdata, 32'h18);
    acc(1'b1, 8'h10, 32'h18);
    @(posedge clk); #1; chk(irq[0] == 1'b1, "R7 write 1 keeps flag", {31'h0, irq[0]}, 32'h1);
    acc(1'b1, 8'h10, 32'h08);
    @(posedge clk); #1; chk(irq[0] == 1'b0, "R7 write 0 clears", {31'h0, irq[0]}, 32'h0);

    // R5 stop holds, restart resumes
    acc(1'b1, 8'h0C, 32'd100);
    repeat (40) @(posedge clk); #1;
    acc(1'b0, 8'h0C, '0); chk(rdata == 32'd100, "R5 stopped hold", rdata, 32'd100);
    acc(1'b1, 8'h04, 32'h1);
    repeat (40) @(posedge clk); #1;
    acc(1'b0, 8'h0C, '0); v0 = rdata;
    chk(v0 < 32'd100 && v0 >= 32'd88, "R4 running counts", v0, 32'd90);
    acc(1'b1, 8'h04, 32'h0);
    acc(1'b0, 8'h0C, '0); v1 = rdata;
    repeat (30) @(posedge clk); #1;
    acc(1'b0, 8'h0C, '0); v2 = rdata;
    chk(v2 == v1, "R5 hold after stop", v2, v1);
    acc(1'b1, 8'h04, 32'h1);
    repeat (20) @(posedge clk); #1;
    acc(1'b0, 8'h0C, '0);
    chk(rdata < v2 && rdata > 32'd50, "R5 resume from held", rdata, v2 - 32'd5);
    acc(1'b0, 8'h18, '0); chk(rdata == 32'h66, "R4 ch1 idle", rdata, 32'h66);

    // R2 start read-back
    acc(1'b1, 8'h04, 32'h0000_1230);
    acc(1'b0, 8'h04, '0); chk(rdata == 32'h0000_1230, "R2 start readback", rdata, 32'h1230);

    // R9 reduced build
    acc(1'b1, 8'h20, 32'h1); chk(err_s == 1'b1, "R9 no ch2 space", {31'h0, err_s}, 32'h1);
    acc(1'b1, 8'h04, 32'h4); chk(err_s == 1'b1, "R9 start bit2", {31'h0, err_s}, 32'h1);
    chk(err == 1'b0, "R9 full build start bit2 ok", {31'h0, err}, 32'h0);
    acc(1'b0, 8'h00, '0); chk(err_s == 1'b1, "R9 no outctl", {31'h0, err_s}, 32'h1);
    acc(1'b0, 8'h04, '0); chk(rdata_s == 32'h4, "R2 small start readback", rdata_s, 32'h4);
    chk(err_s == 1'b0, "R9 err one cycle", {31'h0, err_s}, 32'h0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule